// File: doc/BRIEF.md
# Atomic and Load-Linked Reservation Arbiter

This block sits in the admission path of a per-core request sequencer. Each incoming request (type, processor ID, line address) gets one verdict one cycle later: admitted, refused, conditional-store failure, or protocol error. Read-modify-write sequences are kept exclusive to a single processor ID. An owner register records that ID, and a nesting counter tracks how deeply the sequence has been entered. While an owner is held, every request from any other processor is turned away.

The block also tracks load-linked/store-conditional reservations on data-cache lines. A small table of reservation entries holds them, and each entry is tagged with this sequencer's identity. A completing locked read sets a reservation on its line. A locked (conditional) write is checked at admission. If it holds a valid reservation, it consumes it and goes on. If it does not, it gets the fail verdict and is not forwarded. An external invalidate input removes a reservation when the line's ownership is lost elsewhere. Instruction fetches never touch the owner or the reservations.

Top module: `arb`

## Requirements
- R1: Reset leaves no owner, a zero nesting count, no reservations, and all four verdict outputs low. A request after reset behaves as if nothing had happened before the reset.
- R2: Each cycle with `reqValid` high is followed, one cycle later, by exactly one of `rspAdmit`, `rspRefuse`, `rspScFail`, `rspProtoErr`. In the cycle after a cycle with `reqValid` low, all four are low.
- R3: While an owner is held, any request whose `reqProc` differs from the owner is refused, whatever its kind. The request kinds are encoded on `reqKind` as 0 load, 1 store, 2 fetch, 3 RMW read, 4 RMW write, 5 locked read, 6 locked write; 7 behaves as a load.
- R4: An admitted RMW read (kind 3) takes ownership for the requester if no owner is held, then increments the nesting count. An RMW read arriving with the count at its maximum (2^CNT_W−1) is refused.
- R5: An admitted RMW write (kind 4) decrements the nesting count. When the count reaches zero the owner is released.
- R6: An RMW write arriving with no owner held gives `rspProtoErr` and changes no state.
- R7: A pulse on `cplValid` records a reservation on `cplLine`. Up to NUM_RSV distinct lines can be reserved at once.
- R8: A locked write (kind 6) to a line without a reservation gives `rspScFail` and is not admitted.
- R9: A locked write to a reserved line is admitted and removes that reservation, so a second locked write to the same line fails.
- R10: A pulse on `invValid` removes the reservation on `invLine` only. Reservations on other lines stay.
- R11: Loads, stores, fetches and locked reads from the owner, or from anyone when no owner is held, are admitted. They do not alter the owner or the reservations; in particular, a plain store to a reserved line leaves the reservation intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqKind | input | 3 | Request kind (encoding in R3) |
| reqProc | input | PROC_W | Requesting processor ID |
| reqLine | input | LINE_W | Line address of the request |
| cplValid | input | 1 | Locked read completed this cycle |
| cplLine | input | LINE_W | Line of the completed locked read |
| invValid | input | 1 | Reservation loss for a line |
| invLine | input | LINE_W | Line whose reservation is lost |
| rspAdmit | output | 1 | Request admitted (registered) |
| rspRefuse | output | 1 | Request refused, retry later |
| rspScFail | output | 1 | Conditional store failed, not forwarded |
| rspProtoErr | output | 1 | RMW write without an open sequence |

## Verification
The hardest case to reach from the ports is a saturated nesting count with a foreign processor waiting. It takes three consecutive RMW reads from one ID before a fourth is refused for the count and not for ownership. The stimulus therefore nests to the limit first. It then shows that a foreign request is still refused at every level while the writes unwind, and that the foreign request is admitted only after the last write. Reservation persistence is only visible through a later conditional store, so every invalidate and every plain store to a reserved line is followed by a locked write to the same line.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [2:0] {
    KIND_LOAD    = 3'd0,
    KIND_STORE   = 3'd1,
    KIND_FETCH   = 3'd2,
    KIND_RMW_RD  = 3'd3,
    KIND_RMW_WR  = 3'd4,
    KIND_LL      = 3'd5,
    KIND_SC      = 3'd6,
    KIND_SPARE   = 3'd7
  } reqKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic takeOwner;
    logic incCnt;
    logic decCnt;
    logic dropRsv;
  } arbStrobes_t;

endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
#(
  parameter int PROC_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqKind,
  input  logic [PROC_W-1:0] reqProc,
  input  logic              ownerValid,
  input  logic [PROC_W-1:0] ownerId,
  input  logic              cntZero,
  input  logic              cntFull,
  input  logic              rsvHit,
  output arbStrobes_t       strobes,
  output logic              rspAdmit,
  output logic              rspRefuse,
  output logic              rspScFail,
  output logic              rspProtoErr
);

  logic foreignReq;
  logic nAdmit, nRefuse, nScFail, nProto;
  reqKind_e kind;

  assign kind       = reqKind_e'(reqKind);
  assign foreignReq = ownerValid && (reqProc != ownerId);

  always_comb begin
    strobes = '0;
    nAdmit  = 1'b0;
    nRefuse = 1'b0;
    nScFail = 1'b0;
    nProto  = 1'b0;
    if (reqValid) begin
      if (foreignReq) begin
        nRefuse = 1'b1;
      end else begin
        unique case (kind)
          KIND_RMW_RD: begin
            if (cntFull) begin
              nRefuse = 1'b1;
            end else begin
              nAdmit            = 1'b1;
              strobes.takeOwner = !ownerValid;
              strobes.incCnt    = 1'b1;
            end
          end
          KIND_RMW_WR: begin
            if (!ownerValid || cntZero) begin
              nProto = 1'b1;
            end else begin
              nAdmit         = 1'b1;
              strobes.decCnt = 1'b1;
            end
          end
          KIND_SC: begin
            if (rsvHit) begin
              nAdmit          = 1'b1;
              strobes.dropRsv = 1'b1;
            end else begin
              nScFail = 1'b1;
            end
          end
          default: nAdmit = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspAdmit    <= 1'b0;
      rspRefuse   <= 1'b0;
      rspScFail   <= 1'b0;
      rspProtoErr <= 1'b0;
    end else begin
      rspAdmit    <= nAdmit;
      rspRefuse   <= nRefuse;
      rspScFail   <= nScFail;
      rspProtoErr <= nProto;
    end
  end

endmodule

// File: rtl/arb_data.sv
module arb_data
  import arb_pkg::*;
#(
  parameter int PROC_W  = 4,
  parameter int LINE_W  = 26,
  parameter int CNT_W   = 2,
  parameter int NUM_RSV = 4,
  parameter int ID_W    = 4,
  parameter int SEQ_ID  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PROC_W-1:0] reqProc,
  input  logic [LINE_W-1:0] reqLine,
  input  logic              cplValid,
  input  logic [LINE_W-1:0] cplLine,
  input  logic              invValid,
  input  logic [LINE_W-1:0] invLine,
  input  arbStrobes_t       strobes,
  output logic              ownerValid,
  output logic [PROC_W-1:0] ownerId,
  output logic [CNT_W-1:0]  ownerCnt,
  output logic              cntZero,
  output logic              cntFull,
  output logic              rsvHit
);

  localparam int IDX_W = (NUM_RSV > 1) ? $clog2(NUM_RSV) : 1;
  localparam logic [ID_W-1:0] MY_TAG = ID_W'(SEQ_ID);

  // owner and nesting counter
  assign cntZero = (ownerCnt == '0);
  assign cntFull = &ownerCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ownerValid <= 1'b0;
      ownerId    <= '0;
      ownerCnt   <= '0;
    end else begin
      if (strobes.takeOwner) begin
        ownerValid <= 1'b1;
        ownerId    <= reqProc;
      end
      if (strobes.incCnt) begin
        ownerCnt <= ownerCnt + CNT_W'(1);
      end else if (strobes.decCnt) begin
        ownerCnt <= ownerCnt - CNT_W'(1);
        if (ownerCnt == CNT_W'(1)) begin
          ownerValid <= 1'b0;
          ownerId    <= '0;
        end
      end
    end
  end

  // reservation table
  logic              rsvValid [NUM_RSV];
  logic [LINE_W-1:0] rsvLine  [NUM_RSV];
  logic [ID_W-1:0]   rsvTag   [NUM_RSV];
  logic              nValid   [NUM_RSV];
  logic [LINE_W-1:0] nLine    [NUM_RSV];
  logic [ID_W-1:0]   nTag     [NUM_RSV];
  logic [NUM_RSV-1:0] hitVec;
  logic [NUM_RSV-1:0] cplMatch;
  logic [IDX_W-1:0]  rrPtr;
  logic [IDX_W-1:0]  freeIdx;
  logic [IDX_W-1:0]  setIdx;
  logic              hasFree;
  logic              bumpPtr;

  for (genvar g = 0; g < NUM_RSV; g++) begin : gMatch
    assign hitVec[g]   = rsvValid[g] && (rsvLine[g] == reqLine) && (rsvTag[g] == MY_TAG);
    assign cplMatch[g] = rsvValid[g] && (rsvLine[g] == cplLine) && (rsvTag[g] == MY_TAG);
  end

  assign rsvHit = |hitVec;

  always_comb begin
    hasFree = 1'b0;
    freeIdx = '0;
    for (int i = NUM_RSV - 1; i >= 0; i--) begin
      if (!rsvValid[i]) begin
        hasFree = 1'b1;
        freeIdx = IDX_W'(i);
      end
    end
  end

  assign setIdx = hasFree ? freeIdx : rrPtr;

  always_comb begin
    bumpPtr = 1'b0;
    for (int i = 0; i < NUM_RSV; i++) begin
      nValid[i] = rsvValid[i];
      nLine[i]  = rsvLine[i];
      nTag[i]   = rsvTag[i];
    end
    if (cplValid && !(|cplMatch)) begin
      nValid[setIdx] = 1'b1;
      nLine[setIdx]  = cplLine;
      nTag[setIdx]   = MY_TAG;
      bumpPtr        = !hasFree;
    end
    for (int i = 0; i < NUM_RSV; i++) begin
      if (strobes.dropRsv && (nLine[i] == reqLine)) nValid[i] = 1'b0;
      if (invValid && (nLine[i] == invLine))        nValid[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= '0;
      for (int i = 0; i < NUM_RSV; i++) begin
        rsvValid[i] <= 1'b0;
        rsvLine[i]  <= '0;
        rsvTag[i]   <= '0;
      end
    end else begin
      if (bumpPtr) begin
        rrPtr <= (rrPtr == IDX_W'(NUM_RSV - 1)) ? '0 : rrPtr + IDX_W'(1);
      end
      for (int i = 0; i < NUM_RSV; i++) begin
        rsvValid[i] <= nValid[i];
        rsvLine[i]  <= nLine[i];
        rsvTag[i]   <= nTag[i];
      end
    end
  end

endmodule

// File: rtl/arb.sv
module arb
  import arb_pkg::*;
#(
  parameter int PROC_W  = 4,
  parameter int LINE_W  = 26,
  parameter int CNT_W   = 2,
  parameter int NUM_RSV = 4,
  parameter int ID_W    = 4,
  parameter int SEQ_ID  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqKind,
  input  logic [PROC_W-1:0] reqProc,
  input  logic [LINE_W-1:0] reqLine,
  input  logic              cplValid,
  input  logic [LINE_W-1:0] cplLine,
  input  logic              invValid,
  input  logic [LINE_W-1:0] invLine,
  output logic              rspAdmit,
  output logic              rspRefuse,
  output logic              rspScFail,
  output logic              rspProtoErr
);

  arbStrobes_t       strobes;
  logic              ownerValid;
  logic [PROC_W-1:0] ownerId;
  logic [CNT_W-1:0]  ownerCnt;
  logic              cntZero;
  logic              cntFull;
  logic              rsvHit;

  arb_ctrl #(.PROC_W(PROC_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqKind(reqKind), .reqProc(reqProc),
    .ownerValid(ownerValid), .ownerId(ownerId),
    .cntZero(cntZero), .cntFull(cntFull), .rsvHit(rsvHit),
    .strobes(strobes),
    .rspAdmit(rspAdmit), .rspRefuse(rspRefuse),
    .rspScFail(rspScFail), .rspProtoErr(rspProtoErr)
  );

  arb_data #(
    .PROC_W(PROC_W), .LINE_W(LINE_W), .CNT_W(CNT_W),
    .NUM_RSV(NUM_RSV), .ID_W(ID_W), .SEQ_ID(SEQ_ID)
  ) uData (
    .clk(clk), .rstN(rstN),
    .reqProc(reqProc), .reqLine(reqLine),
    .cplValid(cplValid), .cplLine(cplLine),
    .invValid(invValid), .invLine(invLine),
    .strobes(strobes),
    .ownerValid(ownerValid), .ownerId(ownerId), .ownerCnt(ownerCnt),
    .cntZero(cntZero), .cntFull(cntFull), .rsvHit(rsvHit)
  );

endmodule

// File: rtl/arb_chk.sv
module arb_chk #(
  parameter int PROC_W = 4,
  parameter int CNT_W  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [2:0]        reqKind,
  input logic [PROC_W-1:0] reqProc,
  input logic              rspAdmit,
  input logic              rspRefuse,
  input logic              rspScFail,
  input logic              rspProtoErr,
  input logic              ownerValid,
  input logic [PROC_W-1:0] ownerId,
  input logic [CNT_W-1:0]  ownerCnt
);

  logic [3:0] verdict;
  assign verdict = {rspAdmit, rspRefuse, rspScFail, rspProtoErr};

  p_one_verdict_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> $countones(verdict) == 1);

  p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> verdict == 4'b0000);

  p_idle_count_r1: assert property (@(posedge clk) disable iff (!rstN)
    !ownerValid |-> ownerCnt == '0);

  p_foreign_refused_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && ownerValid && reqProc != ownerId) |=> rspRefuse);

  p_unwind_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == 3'd4 && ownerValid && ownerCnt != '0 && reqProc == ownerId)
    |=> ownerCnt == ($past(ownerCnt) - CNT_W'(1)));

  p_orphan_write_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == 3'd4 && !ownerValid) |=> (rspProtoErr && !ownerValid && $stable(ownerCnt)));

endmodule

bind arb arb_chk #(.PROC_W(PROC_W), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN),
  .reqValid(reqValid), .reqKind(reqKind), .reqProc(reqProc),
  .rspAdmit(rspAdmit), .rspRefuse(rspRefuse),
  .rspScFail(rspScFail), .rspProtoErr(rspProtoErr),
  .ownerValid(ownerValid), .ownerId(ownerId), .ownerCnt(ownerCnt)
);

// File: tb/sim_arb.sv
`timescale 1ns/1ps
module sim_arb;

  localparam int PROC_W = 4;
  localparam int LINE_W = 26;

  localparam logic [2:0] K_LD = 3'd0, K_ST = 3'd1, K_IF = 3'd2, K_RR = 3'd3,
                         K_RW = 3'd4, K_LL = 3'd5, K_SC = 3'd6;
  localparam logic [3:0] V_ADM = 4'b1000, V_REF = 4'b0100,
                         V_SCF = 4'b0010, V_PRO = 4'b0001, V_NONE = 4'b0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [2:0] reqKind = '0;
  logic [PROC_W-1:0] reqProc = '0;
  logic [LINE_W-1:0] reqLine = '0;
  logic cplValid = 1'b0;
  logic [LINE_W-1:0] cplLine = '0;
  logic invValid = 1'b0;
  logic [LINE_W-1:0] invLine = '0;
  logic rspAdmit, rspRefuse, rspScFail, rspProtoErr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  arb u0 (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqKind(reqKind), .reqProc(reqProc), .reqLine(reqLine),
    .cplValid(cplValid), .cplLine(cplLine), .invValid(invValid), .invLine(invLine),
    .rspAdmit(rspAdmit), .rspRefuse(rspRefuse),
    .rspScFail(rspScFail), .rspProtoErr(rspProtoErr)
  );

  function automatic logic [3:0] verdict();
    return {rspAdmit, rspRefuse, rspScFail, rspProtoErr};
  endfunction

  task automatic chk(string req, logic [3:0] got, logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, got, exp);
    end
  endtask

  task automatic doReq(string req, logic [2:0] k, int p, int ln, logic [3:0] exp);
    @(negedge clk);
    reqValid = 1'b1; reqKind = k; reqProc = PROC_W'(p); reqLine = LINE_W'(ln);
    @(negedge clk);
    chk(req, verdict(), exp);
    reqValid = 1'b0;
  endtask

  task automatic complete(int ln);
    @(negedge clk); cplValid = 1'b1; cplLine = LINE_W'(ln);
    @(negedge clk); cplValid = 1'b0;
  endtask

  task automatic invalidate(int ln);
    @(negedge clk); invValid = 1'b1; invLine = LINE_W'(ln);
    @(negedge clk); invValid = 1'b0;
  endtask

  task automatic applyReset();
    @(negedge clk); rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic testResetAndIdle();
    applyReset();
    chk("R1 outputs after reset", verdict(), V_NONE);
    doReq("R1 SC with no reservation", K_SC, 1, 40, V_SCF);
    doReq("R6 RMW write with no owner", K_RW, 3, 0, V_PRO);
    doReq("R6 state unchanged after orphan write", K_LD, 7, 1, V_ADM);
    @(negedge clk);
    chk("R2 quiet after idle cycle", verdict(), V_NONE);
  endtask

  task automatic testPlain();
    doReq("R11 load", K_LD, 2, 5, V_ADM);
    doReq("R11 store", K_ST, 2, 5, V_ADM);
    doReq("R11 fetch", K_IF, 9, 6, V_ADM);
    doReq("R11 spare kind as load", 3'd7, 9, 6, V_ADM);
  endtask

  task automatic testNesting();
    doReq("R4 first RMW read", K_RR, 1, 100, V_ADM);
    doReq("R3 foreign load refused", K_LD, 2, 7, V_REF);
    doReq("R3 foreign fetch refused", K_IF, 2, 7, V_REF);
    doReq("R11 owner load admitted", K_LD, 1, 7, V_ADM);
    doReq("R4 nested RMW read", K_RR, 1, 100, V_ADM);
    doReq("R4 third RMW read", K_RR, 1, 100, V_ADM);
    doReq("R4 RMW read at max refused", K_RR, 1, 100, V_REF);
    doReq("R5 unwind 1", K_RW, 1, 100, V_ADM);
    doReq("R3 still owned after 1 write", K_ST, 2, 7, V_REF);
    doReq("R5 unwind 2", K_RW, 1, 100, V_ADM);
    doReq("R3 still owned after 2 writes", K_RW, 2, 7, V_REF);
    doReq("R5 unwind 3", K_RW, 1, 100, V_ADM);
    doReq("R5 owner released", K_LD, 2, 7, V_ADM);
    doReq("R6 extra write is error", K_RW, 1, 100, V_PRO);
    doReq("R4 new owner", K_RR, 2, 8, V_ADM);
    doReq("R3 old owner refused", K_RR, 1, 8, V_REF);
    doReq("R5 new owner releases", K_RW, 2, 8, V_ADM);
  endtask

  task automatic testLlSc();
    doReq("R8 SC before LL", K_SC, 1, 200, V_SCF);
    doReq("R11 LL admitted", K_LL, 1, 200, V_ADM);
    doReq("R8 SC before completion", K_SC, 1, 200, V_SCF);
    complete(200);
    doReq("R11 store keeps reservation", K_ST, 1, 200, V_ADM);
    doReq("R9 SC with reservation", K_SC, 1, 200, V_ADM);
    doReq("R9 second SC fails", K_SC, 1, 200, V_SCF);
  endtask

  task automatic testInvalidate();
    complete(300);
    complete(301);
    invalidate(300);
    doReq("R10 invalidated line fails", K_SC, 1, 300, V_SCF);
    doReq("R10 other line kept", K_SC, 1, 301, V_ADM);
  endtask

  task automatic testCapacity();
    for (int i = 0; i < 4; i++) complete(400 + i);
    for (int i = 0; i < 4; i++) doReq("R7 all reservations held", K_SC, 1, 400 + i, V_ADM);
  endtask

  task automatic testForeignSc();
    complete(500);
    doReq("R4 owner for foreign SC test", K_RR, 3, 9, V_ADM);
    doReq("R3 foreign SC refused", K_SC, 4, 500, V_REF);
    doReq("R5 release", K_RW, 3, 9, V_ADM);
    doReq("R9 reservation survived refusal", K_SC, 4, 500, V_ADM);
  endtask

  task automatic testResetClears();
    complete(600);
    doReq("R4 owner before reset", K_RR, 1, 10, V_ADM);
    applyReset();
    doReq("R1 owner cleared by reset", K_LD, 2, 10, V_ADM);
    doReq("R1 reservation cleared by reset", K_SC, 2, 600, V_SCF);
  endtask

  initial begin
    testResetAndIdle();
    testPlain();
    testNesting();
    testLlSc();
    testInvalidate();
    testCapacity();
    testForeignSc();
    testResetClears();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule